// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This unit sits between decode and two execution slots. Each cycle it looks at the two oldest decoded instructions in the fetch window. It decides whether both can leave together as one packet, or whether only the older one leaves. Each instruction carries a class code, a flag that marks a memory reference, and register specifiers. The unit tells the window, in the same cycle, how many entries it consumed. It loads the chosen instructions into a registered issue stage that drives the two execution slots.

Pairing follows a class matrix:

- Two integer instructions may pair.
- One floating and one integer instruction may pair, in either order.
- Two floating instructions pair only as one add and one multiply.
- A packet holds at most one memory reference.
- A branch never occupies the first slot of a pair.
- The younger instruction never pairs if it touches a register that the older one writes.

Back-pressure works as follows. The ready of slot 0 stalls the whole issue stage: while it is low, nothing is consumed and the stage holds its outputs. The ready of slot 1 only forbids pairing.

Top module: `dual_issue_pairer`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `slot0_valid` and `slot1_valid` go to 0 and `issue_count` goes to 0.
- R2: When `s0_ready` is 1, the issue stage loads on the clock edge. `slot0_valid` takes the value of `i0_valid`, and `slot0_payload` takes `i0_payload`. `slot1_valid` is 1 exactly when the pair is taken, and `slot1_payload` then carries `i1_payload`. `issue_count` equals the `take_count` shown in the cycle before. The decision therefore appears one cycle after the window is presented.
- R3: Class codes are 0 integer, 1 floating add, 2 floating multiply, 3 other floating, and 4 branch; codes 5 to 7 behave as integer. Two integer instructions pair. An integer and a floating instruction pair in either order.
- R4: Two floating instructions pair only when one is an add (1) and the other is a multiply (2). Add with add, multiply with multiply, and any pair that includes class 3 with another floating instruction issue singly.
- R5: When both `i0_mem` and `i1_mem` are 1, the pair is refused.
- R6: A branch (class 4) in the older position is never paired. A branch in the younger position may pair.
- R7: A register specifier has its enable in bit INT_W+1 (bit 6 by default) and its file select in bit INT_W (1 = floating). The index is in bits INT_W-1:0. Floating indices compare only the low FP_W bits. If `i0_dst` is enabled, and an enabled `i1_src_a`, `i1_src_b` or `i1_dst` names the same file and the same index, the pair is refused. Specifiers in different files never conflict.
- R8: When `i1_valid` or `s1_ready` is 0, at most one instruction is taken.
- R9: When `s0_ready` is 0, `take_count` is 0, and the slot valids, payloads and `issue_count` keep their values on the next edge.
- R10: When `i0_valid` is 0 and `s0_ready` is 1, `take_count` is 0. On the next edge both slot valids load 0 and `issue_count` loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| i0_valid | input | 1 | Older window entry is present |
| i0_class | input | 3 | Class code of the older entry |
| i0_mem | input | 1 | Older entry references memory |
| i0_dst | input | SPEC_W | Destination specifier of the older entry |
| i0_payload | input | PAYLOAD_W | Opaque instruction bits, older entry |
| i1_valid | input | 1 | Younger window entry is present |
| i1_class | input | 3 | Class code of the younger entry |
| i1_mem | input | 1 | Younger entry references memory |
| i1_src_a | input | SPEC_W | First source specifier, younger entry |
| i1_src_b | input | SPEC_W | Second source specifier, younger entry |
| i1_dst | input | SPEC_W | Destination specifier, younger entry |
| i1_payload | input | PAYLOAD_W | Opaque instruction bits, younger entry |
| take_count | output | 2 | Entries consumed from the window this cycle (0, 1, 2) |
| s0_ready | input | 1 | Slot 0 accepts; low stalls the issue stage |
| s1_ready | input | 1 | Slot 1 accepts; low forbids pairing |
| slot0_valid | output | 1 | Slot 0 holds an instruction |
| slot0_payload | output | PAYLOAD_W | Instruction bits for slot 0 |
| slot1_valid | output | 1 | Slot 1 holds an instruction |
| slot1_payload | output | PAYLOAD_W | Instruction bits for slot 1 |
| issue_count | output | 2 | Instructions in the registered packet |

## Verification
The assertions assume that the class inputs carry only codes 0 to 4. They also assume that the younger entry's fields only matter while `i1_valid` is high. This is why the properties tie class and memory rules to cycles where `take_count` is 2, and never to idle cycles. The stimulus changes inputs only on the falling clock edge and keeps them steady through the rising edge. It sweeps every class pair, both memory flags and both readies, and builds hazards from a small set of specifiers. One of these specifiers is a floating index that differs only in its upper bits.

// File: rtl/dip_pkg.sv
package dip_pkg;

  typedef enum logic [2:0] {
    CL_INT  = 3'd0,
    CL_FADD = 3'd1,
    CL_FMUL = 3'd2,
    CL_FOTH = 3'd3,
    CL_BR   = 3'd4
  } iclass_e;

  function automatic logic class_is_fp(input logic [2:0] c);
    return (c == CL_FADD) || (c == CL_FMUL) || (c == CL_FOTH);
  endfunction

endpackage

// File: rtl/dip_class_rules.sv
module dip_class_rules
  import dip_pkg::*;
(
  input  logic [2:0] c0,
  input  logic [2:0] c1,
  input  logic       m0,
  input  logic       m1,
  output logic       ok
);
  logic both_fp;
  logic fp_combo_ok;
  logic order_ok;
  logic mem_ok;

  always_comb begin
    both_fp     = class_is_fp(c0) && class_is_fp(c1);
    fp_combo_ok = ((c0 == CL_FADD) && (c1 == CL_FMUL)) ||
                  ((c0 == CL_FMUL) && (c1 == CL_FADD));
    order_ok    = (c0 != CL_BR);
    mem_ok      = !(m0 && m1);
    ok          = order_ok && mem_ok && (!both_fp || fp_combo_ok);
  end
endmodule

// File: rtl/dip_hazard.sv
module dip_hazard #(
  parameter int INT_W  = 5,
  parameter int FP_W   = 3,
  localparam int SPEC_W = INT_W + 2,
  localparam int NSPEC  = 3
) (
  input  logic [SPEC_W-1:0] older_dst,
  input  logic [SPEC_W-1:0] y_src_a,
  input  logic [SPEC_W-1:0] y_src_b,
  input  logic [SPEC_W-1:0] y_dst,
  output logic              conflict
);
  localparam int EN_B = INT_W + 1;
  localparam int FL_B = INT_W;

  logic [SPEC_W-1:0] yspec [NSPEC];
  logic [NSPEC-1:0]  hit;

  assign yspec[0] = y_src_a;
  assign yspec[1] = y_src_b;
  assign yspec[2] = y_dst;

  for (genvar g = 0; g < NSPEC; g++) begin : g_cmp
    logic same_file;
    logic same_idx;
    always_comb begin
      same_file = older_dst[FL_B] == yspec[g][FL_B];
      if (older_dst[FL_B])
        same_idx = older_dst[FP_W-1:0] == yspec[g][FP_W-1:0];
      else
        same_idx = older_dst[INT_W-1:0] == yspec[g][INT_W-1:0];
      hit[g] = older_dst[EN_B] && yspec[g][EN_B] && same_file && same_idx;
    end
  end

  assign conflict = |hit;
endmodule

// File: rtl/dip_issue_stage.sv
module dip_issue_stage #(
  parameter int PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 take0,
  input  logic                 take1,
  input  logic [PAYLOAD_W-1:0] p0,
  input  logic [PAYLOAD_W-1:0] p1,
  output logic                 v0_q,
  output logic [PAYLOAD_W-1:0] p0_q,
  output logic                 v1_q,
  output logic [PAYLOAD_W-1:0] p1_q,
  output logic [1:0]           cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0_q  <= 1'b0;
      v1_q  <= 1'b0;
      cnt_q <= 2'd0;
      p0_q  <= '0;
      p1_q  <= '0;
    end else if (load) begin
      v0_q  <= take0;
      v1_q  <= take1;
      cnt_q <= {1'b0, take0} + {1'b0, take1};
      p0_q  <= p0;
      p1_q  <= p1;
    end
  end
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer #(
  parameter int INT_REGS  = 32,
  parameter int FP_REGS   = 8,
  parameter int PAYLOAD_W = 32,
  localparam int INT_W  = $clog2(INT_REGS),
  localparam int FP_W   = $clog2(FP_REGS),
  localparam int SPEC_W = INT_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 i0_valid,
  input  logic [2:0]           i0_class,
  input  logic                 i0_mem,
  input  logic [SPEC_W-1:0]    i0_dst,
  input  logic [PAYLOAD_W-1:0] i0_payload,
  input  logic                 i1_valid,
  input  logic [2:0]           i1_class,
  input  logic                 i1_mem,
  input  logic [SPEC_W-1:0]    i1_src_a,
  input  logic [SPEC_W-1:0]    i1_src_b,
  input  logic [SPEC_W-1:0]    i1_dst,
  input  logic [PAYLOAD_W-1:0] i1_payload,
  output logic [1:0]           take_count,
  input  logic                 s0_ready,
  input  logic                 s1_ready,
  output logic                 slot0_valid,
  output logic [PAYLOAD_W-1:0] slot0_payload,
  output logic                 slot1_valid,
  output logic [PAYLOAD_W-1:0] slot1_payload,
  output logic [1:0]           issue_count
);
  logic class_ok;
  logic reg_conflict;
  logic take0;
  logic take1;

  dip_class_rules u_rules (
    .c0 (i0_class),
    .c1 (i1_class),
    .m0 (i0_mem),
    .m1 (i1_mem),
    .ok (class_ok)
  );

  dip_hazard #(.INT_W(INT_W), .FP_W(FP_W)) u_haz (
    .older_dst (i0_dst),
    .y_src_a   (i1_src_a),
    .y_src_b   (i1_src_b),
    .y_dst     (i1_dst),
    .conflict  (reg_conflict)
  );

  always_comb begin
    take0 = s0_ready && i0_valid;
    take1 = take0 && i1_valid && s1_ready && class_ok && !reg_conflict;
    take_count = {1'b0, take0} + {1'b0, take1};
  end

  dip_issue_stage #(.PAYLOAD_W(PAYLOAD_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (s0_ready),
    .take0 (take0),
    .take1 (take1),
    .p0    (i0_payload),
    .p1    (i1_payload),
    .v0_q  (slot0_valid),
    .p0_q  (slot0_payload),
    .v1_q  (slot1_valid),
    .p1_q  (slot1_payload),
    .cnt_q (issue_count)
  );
endmodule

// File: rtl/dip_checker.sv
module dip_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       s0_ready,
  input logic       s1_ready,
  input logic       i0_valid,
  input logic       i1_valid,
  input logic [2:0] i0_class,
  input logic [2:0] i1_class,
  input logic       i0_mem,
  input logic       i1_mem,
  input logic [1:0] take_count,
  input logic       slot0_valid,
  input logic       slot1_valid,
  input logic [1:0] issue_count
);
  logic i0_fp, i1_fp;
  assign i0_fp = (i0_class >= 3'd1) && (i0_class <= 3'd3);
  assign i1_fp = (i1_class >= 3'd1) && (i1_class <= 3'd3);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!slot0_valid && !slot1_valid && issue_count == 2'd0));

  a_r2_count_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s0_ready |=> issue_count == $past(take_count));

  a_r2_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    slot1_valid |-> slot0_valid);

  a_r4_fp_combo: assert property (@(posedge clk) disable iff (!rst_n)
    (take_count == 2'd2 && i0_fp && i1_fp) |-> (i0_class != i1_class && i0_class != 3'd3 && i1_class != 3'd3));

  a_r5_one_mem: assert property (@(posedge clk) disable iff (!rst_n)
    take_count == 2'd2 |-> !(i0_mem && i1_mem));

  a_r6_branch_first: assert property (@(posedge clk) disable iff (!rst_n)
    take_count == 2'd2 |-> i0_class != 3'd4);

  a_r8_second_ready: assert property (@(posedge clk) disable iff (!rst_n)
    take_count == 2'd2 |-> (i1_valid && s1_ready));

  a_r9_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_ready |-> take_count == 2'd0);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s0_ready |=> ($stable(slot0_valid) && $stable(slot1_valid) && $stable(issue_count)));

  a_r10_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_ready && !i0_valid) |=> (!slot0_valid && !slot1_valid));
endmodule

bind dual_issue_pairer dip_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s0_ready    (s0_ready),
  .s1_ready    (s1_ready),
  .i0_valid    (i0_valid),
  .i1_valid    (i1_valid),
  .i0_class    (i0_class),
  .i1_class    (i1_class),
  .i0_mem      (i0_mem),
  .i1_mem      (i1_mem),
  .take_count  (take_count),
  .slot0_valid (slot0_valid),
  .slot1_valid (slot1_valid),
  .issue_count (issue_count)
);

// File: tb/dual_issue_pairer_test.sv
module dual_issue_pairer_test;
  localparam int SW = 7;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i0_valid = 0, i0_mem = 0, i1_valid = 0, i1_mem = 0;
  logic [2:0] i0_class = 0, i1_class = 0;
  logic [SW-1:0] i0_dst = 0, i1_src_a = 0, i1_src_b = 0, i1_dst = 0;
  logic [PW-1:0] i0_payload = 0, i1_payload = 0;
  logic s0_ready = 0, s1_ready = 0;
  logic [1:0] take_count, issue_count;
  logic slot0_valid, slot1_valid;
  logic [PW-1:0] slot0_payload, slot1_payload;

  int checks = 0;
  int errors = 0;
  int vec = 0;

  logic e_v0 = 0, e_v1 = 0;
  logic [1:0] e_cnt = 0;
  logic [PW-1:0] e_p0 = 0, e_p1 = 0;

  always #2.5 clk = ~clk;

  dual_issue_pairer uut (
    .clk(clk), .rst_n(rst_n),
    .i0_valid(i0_valid), .i0_class(i0_class), .i0_mem(i0_mem), .i0_dst(i0_dst), .i0_payload(i0_payload),
    .i1_valid(i1_valid), .i1_class(i1_class), .i1_mem(i1_mem), .i1_src_a(i1_src_a), .i1_src_b(i1_src_b),
    .i1_dst(i1_dst), .i1_payload(i1_payload),
    .take_count(take_count), .s0_ready(s0_ready), .s1_ready(s1_ready),
    .slot0_valid(slot0_valid), .slot0_payload(slot0_payload),
    .slot1_valid(slot1_valid), .slot1_payload(slot1_payload), .issue_count(issue_count)
  );

  function automatic logic [SW-1:0] spec(input int sel);
    case (sel)
      1: return {1'b1, 1'b0, 5'd3};
      2: return {1'b1, 1'b1, 5'd3};
      3: return {1'b1, 1'b0, 5'd11};
      4: return {1'b1, 1'b1, 5'd11};
      default: return '0;
    endcase
  endfunction

  function automatic bit same_reg(input logic [SW-1:0] a, input logic [SW-1:0] b);
    if (!a[6] || !b[6] || a[5] != b[5]) return 0;
    if (a[5]) return (a[4:0] % 8) == (b[4:0] % 8);
    return a[4:0] == b[4:0];
  endfunction

  function automatic bit exp_pair();
    bit f0, f1, cls;
    f0 = i0_class >= 1 && i0_class <= 3;
    f1 = i1_class >= 1 && i1_class <= 3;
    cls = !(f0 && f1) || (i0_class + i1_class == 3 && i0_class != 0 && i1_class != 0);
    return s0_ready && i0_valid && i1_valid && s1_ready && i0_class != 4 && cls &&
           !(i0_mem && i1_mem) &&
           !same_reg(i0_dst, i1_src_a) && !same_reg(i0_dst, i1_src_b) && !same_reg(i0_dst, i1_dst);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (vector %0d)", req, what, act, exp, vec);
    end
  endtask

  task automatic apply(input string req, input bit v0, input int c0, input bit m0, input int d0,
                       input bit v1, input int c1, input bit m1, input int sa, input int sb, input int d1,
                       input bit r0, input bit r1);
    bit p;
    @(negedge clk);
    vec++;
    i0_valid = v0; i0_class = 3'(c0); i0_mem = m0; i0_dst = spec(d0); i0_payload = PW'(vec);
    i1_valid = v1; i1_class = 3'(c1); i1_mem = m1;
    i1_src_a = spec(sa); i1_src_b = spec(sb); i1_dst = spec(d1); i1_payload = ~PW'(vec);
    s0_ready = r0; s1_ready = r1;
    #1;
    p = exp_pair();
    check(req, "take_count", int'(take_count), (r0 && v0) ? (p ? 2 : 1) : 0);
    if (r0) begin
      e_v0 = v0; e_v1 = p; e_cnt = 2'(int'(v0) + int'(p));
      e_p0 = i0_payload; e_p1 = i1_payload;
    end
    @(posedge clk);
    #1;
    check(req, "slot0_valid", int'(slot0_valid), int'(e_v0));
    check(req, "slot1_valid", int'(slot1_valid), int'(e_v1));
    check(req, "issue_count", int'(issue_count), int'(e_cnt));
    if (e_v0) check(req, "slot0_payload", int'(slot0_payload), int'(e_p0));
    if (e_v1) check(req, "slot1_payload", int'(slot1_payload), int'(e_p1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "slot0_valid", int'(slot0_valid), 0);
    check("R1", "slot1_valid", int'(slot1_valid), 0);
    check("R1", "issue_count", int'(issue_count), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R8: class matrix x memory flags x second valid x slot-1 ready
    for (int c0 = 0; c0 < 5; c0++)
      for (int c1 = 0; c1 < 5; c1++)
        for (int m = 0; m < 4; m++)
          for (int q = 0; q < 4; q++)
            apply("R3/R4/R5/R6/R8", 1, c0, m[0], 0, q[0], c1, m[1], 0, 0, 0, 1, q[1]);

    // R7: register hazards between integer and floating specifiers
    for (int d0 = 0; d0 < 3; d0++)
      for (int sa = 0; sa < 5; sa++)
        for (int sb = 0; sb < 5; sb++)
          for (int d1 = 0; d1 < 5; d1++)
            apply("R7", 1, 0, 0, d0, 1, 0, 0, sa, sb, d1, 1, 1);

    // R9: stall holds the issue stage and consumes nothing
    for (int k = 0; k < 8; k++) begin
      apply("R2", 1, 1, 0, 0, 1, 2, 0, 0, 0, 0, 1, 1);
      apply("R9", 1, k % 5, 0, 0, 1, 0, 0, 0, 0, 0, 0, k[0]);
      apply("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    end

    // R10: empty older entry issues nothing, even with a younger one present
    for (int k = 0; k < 4; k++) begin
      apply("R2", 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1);
      apply("R10", 0, 0, 0, 0, k[0], 0, 0, 0, 0, 0, 1, k[1]);
    end

    // R1: reset in mid-stream clears a loaded stage
    apply("R2", 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1", "slot0_valid", int'(slot0_valid), 0);
    check("R1", "slot1_valid", int'(slot1_valid), 0);
    check("R1", "issue_count", int'(issue_count), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule